// File: doc/BRIEF.md
# Fair-Share Processor Allocator

This block hands free worker processors to users who ask for one, in an order set by a signed usage score kept for each user. A user raises a one-cycle request strobe. The request stays pending until a processor is granted to it. When a processor finishes, a release event naming that processor returns it to the free pool. Whenever at least one processor is free and at least one user is pending, the block grants the lowest-numbered free processor to the pending user with the lowest score.

A periodic tick updates every score from the state the user is in. A user that holds processors gains a fixed amount per processor held. A user that is waiting and holds nothing loses a fixed amount, so its score can go below zero. A user that is idle moves a step toward zero. Heavy users therefore fall back in line, and users that have waited a long time move to the front. The scores can be read at all times as a flat vector.

Top module: `fairshare_alloc`

## Requirements
- R1: After reset every score is 0, no request is pending, every processor is free and `grant_valid_o` is low.
- R2: A request strobe on `req_i[u]` is latched at the next clock edge. If a processor is free at the following edge, the grant appears on that second edge and takes the lowest-indexed free processor.
- R3: A pending request stays pending until it is granted. A further strobe from a user that already has a request pending is ignored and does not produce a second grant.
- R4: On a tick, a user that holds k>0 processors has its score raised by k times INC_STEP. Scores change only on ticks.
- R5: On a tick, a user that holds no processor and has a pending request has its score lowered by DEC_STEP, and the score may go below zero.
- R6: On a tick, a user that holds nothing and has nothing pending moves toward zero by DECAY_STEP, stopping at zero without crossing it.
- R7: Scores are 16-bit two's complement and saturate at +32767 and -32768.
- R8: Each grant goes to the pending user whose score is lowest, compared as signed values.
- R9: When several pending users share the lowest score, the one with the lowest user index wins.
- R10: A release event on a held processor frees it at that clock edge. It can be granted again from the next edge onward.
- R11: A grant is a `grant_valid_o` pulse one cycle long, with the user and processor IDs valid in that cycle. At most one grant is issued per cycle.
- R12: The score of user u is on `score_o[16*u+15:16*u]`. Tick updates use the holding and pending state from before the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | N_USERS | Per-user request strobe |
| free_valid_i | input | 1 | Processor release event |
| free_proc_i | input | clog2(N_PROCS) | Index of the released processor |
| tick_i | input | 1 | Interval tick for score update |
| grant_valid_o | output | 1 | Grant pulse |
| grant_user_o | output | clog2(N_USERS) | User receiving the grant |
| grant_proc_o | output | clog2(N_PROCS) | Processor granted |
| score_o | output | 16*N_USERS | Packed signed scores, user 0 in the low bits |

## Verification
Several patterns drive the selection logic, each with a distinct purpose:
- Two users requesting at once with equal scores shows whether the index tiebreak is applied.
- A lower-scoring user with a higher index competing against a higher-scoring user with a lower index shows whether the choice follows the score rather than the index.
- Request and release sequences where processors run out show that waiting users are served only after a release.
- A repeated request during a wait shows whether a duplicate strobe leaks a second grant.

Ticks are applied in every user state (holding, waiting and idle, from both positive and negative scores) so that each update rule is seen on its own. A long run of ticks drives scores into both saturation limits.

// File: rtl/fsa_pkg.sv
package fsa_pkg;
  localparam int SCORE_W   = 16;
  localparam int SCORE_MAX = (2 ** (SCORE_W - 1)) - 1;
  localparam int SCORE_MIN = -(2 ** (SCORE_W - 1));
  typedef logic signed [SCORE_W-1:0] score_t;
endpackage

// File: rtl/fsa_score_cell.sv
module fsa_score_cell
  import fsa_pkg::*;
#(
  parameter int CNT_W      = 3,
  parameter int INC_STEP   = 4,
  parameter int DEC_STEP   = 2,
  parameter int DECAY_STEP = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] held_i,
  input  logic             pending_i,
  output score_t           score_o
);
  score_t score_q;
  int     cur;
  int     nxt;
  score_t sat;

  always_comb begin
    cur = int'(score_q);
    if (held_i != '0)    nxt = cur + INC_STEP * int'(held_i);
    else if (pending_i)  nxt = cur - DEC_STEP;
    else if (cur > 0)    nxt = (cur > DECAY_STEP) ? cur - DECAY_STEP : 0;
    else if (cur < 0)    nxt = (cur < -DECAY_STEP) ? cur + DECAY_STEP : 0;
    else                 nxt = 0;
    if (nxt > SCORE_MAX)      sat = score_t'(SCORE_MAX);
    else if (nxt < SCORE_MIN) sat = score_t'(SCORE_MIN);
    else                      sat = score_t'(nxt);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     score_q <= '0;
    else if (tick_i) score_q <= sat;
  end

  assign score_o = score_q;
endmodule

// File: rtl/fsa_pick_min.sv
module fsa_pick_min
  import fsa_pkg::*;
#(
  parameter int N_USERS = 4,
  localparam int UW = (N_USERS > 1) ? $clog2(N_USERS) : 1
) (
  input  logic [N_USERS-1:0] pending_i,
  input  score_t             scores_i [N_USERS],
  output logic               found_o,
  output logic [UW-1:0]      user_o
);
  score_t best;

  // strict less-than keeps the lowest index on ties
  always_comb begin
    found_o = 1'b0;
    user_o  = '0;
    best    = '0;
    for (int u = 0; u < N_USERS; u++) begin
      if (pending_i[u] && (!found_o || scores_i[u] < best)) begin
        found_o = 1'b1;
        user_o  = UW'(u);
        best    = scores_i[u];
      end
    end
  end
endmodule

// File: rtl/fsa_proc_table.sv
module fsa_proc_table #(
  parameter int N_USERS = 4,
  parameter int N_PROCS = 4,
  localparam int UW    = (N_USERS > 1) ? $clog2(N_USERS) : 1,
  localparam int PW    = (N_PROCS > 1) ? $clog2(N_PROCS) : 1,
  localparam int CNT_W = $clog2(N_PROCS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             grant_i,
  input  logic [UW-1:0]    grant_user_i,
  input  logic             free_valid_i,
  input  logic [PW-1:0]    free_proc_i,
  output logic [N_PROCS-1:0] busy_o,
  output logic             any_free_o,
  output logic [PW-1:0]    free_idx_o,
  output logic [CNT_W-1:0] held_o [N_USERS]
);
  logic [N_PROCS-1:0] busy_q;
  logic [UW-1:0]      owner_q [N_PROCS];

  always_comb begin
    any_free_o = 1'b0;
    free_idx_o = '0;
    for (int p = N_PROCS - 1; p >= 0; p--) begin
      if (!busy_q[p]) begin
        any_free_o = 1'b1;
        free_idx_o = PW'(p);
      end
    end
  end

  always_comb begin
    for (int u = 0; u < N_USERS; u++) begin
      held_o[u] = '0;
      for (int p = 0; p < N_PROCS; p++)
        if (busy_q[p] && owner_q[p] == UW'(u)) held_o[u] = held_o[u] + CNT_W'(1);
    end
  end

  for (genvar p = 0; p < N_PROCS; p++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        busy_q[p]  <= 1'b0;
        owner_q[p] <= '0;
      end else if (grant_i && any_free_o && free_idx_o == PW'(p)) begin
        busy_q[p]  <= 1'b1;
        owner_q[p] <= grant_user_i;
      end else if (free_valid_i && free_proc_i == PW'(p)) begin
        busy_q[p]  <= 1'b0;
      end
    end
  end

  assign busy_o = busy_q;
endmodule

// File: rtl/fairshare_alloc.sv
module fairshare_alloc
  import fsa_pkg::*;
#(
  parameter int N_USERS    = 4,
  parameter int N_PROCS    = 4,
  parameter int INC_STEP   = 4,
  parameter int DEC_STEP   = 2,
  parameter int DECAY_STEP = 1,
  localparam int UW    = (N_USERS > 1) ? $clog2(N_USERS) : 1,
  localparam int PW    = (N_PROCS > 1) ? $clog2(N_PROCS) : 1,
  localparam int CNT_W = $clog2(N_PROCS + 1)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [N_USERS-1:0]         req_i,
  input  logic                       free_valid_i,
  input  logic [PW-1:0]              free_proc_i,
  input  logic                       tick_i,
  output logic                       grant_valid_o,
  output logic [UW-1:0]              grant_user_o,
  output logic [PW-1:0]              grant_proc_o,
  output logic [N_USERS*SCORE_W-1:0] score_o
);
  logic [N_USERS-1:0] pending_q;
  logic [N_USERS-1:0] grant_mask;
  logic [N_PROCS-1:0] busy;
  logic               any_free;
  logic [PW-1:0]      free_idx;
  logic [CNT_W-1:0]   held [N_USERS];
  score_t             scores [N_USERS];
  logic               found;
  logic [UW-1:0]      win_user;
  logic               grant_now;

  fsa_pick_min #(.N_USERS(N_USERS)) u_pick (
    .pending_i(pending_q), .scores_i(scores), .found_o(found), .user_o(win_user)
  );

  assign grant_now = found & any_free;

  fsa_proc_table #(.N_USERS(N_USERS), .N_PROCS(N_PROCS)) u_table (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .grant_i(grant_now), .grant_user_i(win_user),
    .free_valid_i(free_valid_i), .free_proc_i(free_proc_i),
    .busy_o(busy), .any_free_o(any_free), .free_idx_o(free_idx), .held_o(held)
  );

  for (genvar u = 0; u < N_USERS; u++) begin : g_user
    fsa_score_cell #(
      .CNT_W(CNT_W), .INC_STEP(INC_STEP), .DEC_STEP(DEC_STEP), .DECAY_STEP(DECAY_STEP)
    ) u_cell (
      .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i),
      .held_i(held[u]), .pending_i(pending_q[u]), .score_o(scores[u])
    );
    assign score_o[u*SCORE_W +: SCORE_W] = scores[u];
    assign grant_mask[u] = grant_now && (win_user == UW'(u));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pending_q     <= '0;
      grant_valid_o <= 1'b0;
      grant_user_o  <= '0;
      grant_proc_o  <= '0;
    end else begin
      // duplicate strobes while pending are dropped
      pending_q     <= (pending_q & ~grant_mask) | (req_i & ~pending_q);
      grant_valid_o <= grant_now;
      if (grant_now) begin
        grant_user_o <= win_user;
        grant_proc_o <= free_idx;
      end
    end
  end
endmodule

// File: rtl/fsa_checker.sv
module fsa_checker
  import fsa_pkg::*;
#(
  parameter int N_USERS = 4,
  parameter int N_PROCS = 4,
  localparam int UW = (N_USERS > 1) ? $clog2(N_USERS) : 1,
  localparam int PW = (N_PROCS > 1) ? $clog2(N_PROCS) : 1
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       tick_i,
  input logic                       grant_valid_o,
  input logic [UW-1:0]              grant_user_o,
  input logic [PW-1:0]              grant_proc_o,
  input logic [N_USERS*SCORE_W-1:0] score_o,
  input logic [N_USERS-1:0]         pending_q,
  input logic [N_PROCS-1:0]         busy
);
  logic [N_USERS*SCORE_W-1:0] prev_score;
  logic [N_USERS-1:0]         prev_pending;
  logic [N_PROCS-1:0]         prev_busy;
  logic [N_USERS-1:0]         gmask;
  score_t                     win_prev;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_score   <= '0;
      prev_pending <= '0;
      prev_busy    <= '0;
    end else begin
      prev_score   <= score_o;
      prev_pending <= pending_q;
      prev_busy    <= busy;
    end
  end

  assign gmask    = grant_valid_o ? (N_USERS'(1) << grant_user_o) : '0;
  assign win_prev = prev_score[grant_user_o*SCORE_W +: SCORE_W];

  AST_GRANT_TO_PENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_valid_o |-> prev_pending[grant_user_o]);  // R2

  AST_GRANT_PROC_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_valid_o |-> !prev_busy[grant_proc_o]);  // R10

  AST_PENDING_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((prev_pending & ~gmask) & ~pending_q) == '0);  // R3

  AST_SCORE_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(tick_i) |-> $stable(score_o));  // R4

  for (genvar u = 0; u < N_USERS; u++) begin : g_min
    score_t us;
    assign us = prev_score[u*SCORE_W +: SCORE_W];
    AST_LOWEST_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (grant_valid_o && prev_pending[u]) |->
        ((win_prev < us) || (win_prev == us && grant_user_o <= UW'(u))));  // R8 R9
  end
endmodule

bind fairshare_alloc fsa_checker #(.N_USERS(N_USERS), .N_PROCS(N_PROCS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i),
  .grant_valid_o(grant_valid_o), .grant_user_o(grant_user_o), .grant_proc_o(grant_proc_o),
  .score_o(score_o), .pending_q(pending_q), .busy(busy)
);

// File: tb/tb_fairshare_alloc.sv
`timescale 1ns/1ps
module tb_fairshare_alloc;
  localparam int NU = 4;
  localparam int NP = 2;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [NU-1:0] req_i = '0;
  logic          free_valid_i = 1'b0;
  logic [0:0]    free_proc_i = '0;
  logic          tick_i = 1'b0;
  logic          grant_valid_o;
  logic [1:0]    grant_user_o;
  logic [0:0]    grant_proc_o;
  logic [NU*16-1:0] score_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  fairshare_alloc #(.N_USERS(NU), .N_PROCS(NP), .INC_STEP(3), .DEC_STEP(2), .DECAY_STEP(1)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .free_valid_i(free_valid_i),
    .free_proc_i(free_proc_i), .tick_i(tick_i), .grant_valid_o(grant_valid_o),
    .grant_user_o(grant_user_o), .grant_proc_o(grant_proc_o), .score_o(score_o)
  );

  typedef struct packed {
    logic [3:0]         req;
    logic               fv;
    logic               fp;
    logic               tk;
    logic               gv;
    logic [1:0]         gu;
    logic               gp;
    logic [1:0]         cu;
    logic signed [15:0] cs;
  } vec_t;

  // INC=3 DEC=2 DECAY=1, two processors
  localparam vec_t VECS [29] = '{
    '{4'b0001, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 2'd0,  16'sd0},   // R2 latch
    '{4'b0000, 1'b0, 1'b0, 1'b0, 1'b1, 2'd0, 1'b0, 2'd0,  16'sd0},   // R2 grant
    '{4'b0110, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 2'd1,  16'sd0},
    '{4'b0000, 1'b0, 1'b0, 1'b1, 1'b1, 2'd1, 1'b1, 2'd1, -16'sd2},   // R9 R12 R5
    '{4'b0000, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 1'b0, 2'd2, -16'sd4},   // R5
    '{4'b0000, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 2'd0,  16'sd6},   // R4 R10
    '{4'b1000, 1'b0, 1'b0, 1'b0, 1'b1, 2'd2, 1'b0, 2'd1,  16'sd1},   // R10
    '{4'b0000, 1'b1, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0, 2'd3,  16'sd0},
    '{4'b0000, 1'b0, 1'b0, 1'b0, 1'b1, 2'd3, 1'b1, 2'd2, -16'sd4},
    '{4'b0000, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 1'b0, 2'd3,  16'sd3},   // R4
    '{4'b0011, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 2'd0,  16'sd5},   // R6
    '{4'b0000, 1'b1, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0, 2'd1,  16'sd0},
    '{4'b0000, 1'b0, 1'b0, 1'b0, 1'b1, 2'd1, 1'b1, 2'd2, -16'sd1},   // R8
    '{4'b0000, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 2'd0,  16'sd5},
    '{4'b0000, 1'b0, 1'b0, 1'b0, 1'b1, 2'd0, 1'b0, 2'd3,  16'sd3},
    '{4'b0000, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 1'b0, 2'd2,  16'sd0},   // R6
    '{4'b0000, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 1'b0, 2'd0,  16'sd11},
    '{4'b0000, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 1'b0, 2'd3,  16'sd0},   // R6
    '{4'b1100, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 2'd1,  16'sd9},
    '{4'b0000, 1'b1, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0, 2'd2,  16'sd0},
    '{4'b0000, 1'b0, 1'b0, 1'b0, 1'b1, 2'd2, 1'b1, 2'd3,  16'sd0},   // R9
    '{4'b0000, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 2'd0,  16'sd14},
    '{4'b0000, 1'b0, 1'b0, 1'b0, 1'b1, 2'd3, 1'b0, 2'd1,  16'sd9},
    '{4'b0001, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 2'd0,  16'sd14},
    '{4'b0001, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 2'd0,  16'sd14},  // R3
    '{4'b0000, 1'b1, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0, 2'd2,  16'sd0},
    '{4'b0000, 1'b0, 1'b0, 1'b0, 1'b1, 2'd0, 1'b1, 2'd0,  16'sd14},
    '{4'b0000, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 2'd3,  16'sd0},
    '{4'b0000, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 2'd3,  16'sd0}    // R3 no second grant
  };

  function automatic logic signed [15:0] sc(input int u);
    return score_o[u*16 +: 16];
  endfunction

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic apply_reset();
    @(negedge clk_i);
    rst_ni = 1'b0; req_i = '0; free_valid_i = 1'b0; tick_i = 1'b0;
    @(negedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  initial begin
    apply_reset();
    chk("R1 grant_valid", grant_valid_o, 0);
    for (int u = 0; u < NU; u++) chk("R1 score", sc(u), 0);

    for (int i = 0; i < 29; i++) begin
      req_i = VECS[i].req; free_valid_i = VECS[i].fv; free_proc_i = VECS[i].fp;
      tick_i = VECS[i].tk;
      @(negedge clk_i);
      chk($sformatf("R11 row %0d grant_valid", i), grant_valid_o, VECS[i].gv);
      if (VECS[i].gv) begin
        chk($sformatf("R8 row %0d grant_user", i), grant_user_o, VECS[i].gu);
        chk($sformatf("R2 row %0d grant_proc", i), grant_proc_o, VECS[i].gp);
      end
      chk($sformatf("R12 row %0d score u%0d", i, VECS[i].cu), sc(int'(VECS[i].cu)), VECS[i].cs);
    end
    req_i = '0; free_valid_i = 1'b0; tick_i = 1'b0;

    // R1 mid-run reset clears scores
    apply_reset();
    chk("R1 grant_valid after reset", grant_valid_o, 0);
    chk("R1 score u0 after reset", sc(0), 0);

    // R7 saturation: u0,u1 hold, u2 waits
    req_i = 4'b0011;
    @(negedge clk_i); req_i = '0;
    @(negedge clk_i);
    chk("R9 tie grant u0", grant_user_o, 0);
    @(negedge clk_i);
    chk("R2 second grant proc", grant_proc_o, 1);
    req_i = 4'b0100;
    @(negedge clk_i); req_i = '0;
    tick_i = 1'b1;
    repeat (16400) @(negedge clk_i);
    tick_i = 1'b0;
    @(negedge clk_i);
    chk("R7 upper limit u0", sc(0), 32767);
    chk("R7 upper limit u1", sc(1), 32767);
    chk("R7 lower limit u2", sc(2), -32768);
    chk("R5 no grant while full", grant_valid_o, 0);

    // R10 release then waiting user served next edge
    free_valid_i = 1'b1; free_proc_i = 1'b1;
    @(negedge clk_i); free_valid_i = 1'b0;
    chk("R10 no grant at release edge", grant_valid_o, 0);
    @(negedge clk_i);
    chk("R10 grant after release", grant_valid_o, 1);
    chk("R10 grant user", grant_user_o, 2);
    chk("R10 grant proc", grant_proc_o, 1);
    @(negedge clk_i);
    chk("R11 pulse one cycle", grant_valid_o, 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1_900_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule